// File: doc/BRIEF.md
# Tagged Memory Word Access Controller

This block fronts a small word-addressed store in which every 64-bit word carries four state bits beside its data. The first is an occupancy bit (full or empty) that acts as a lock. The second marks the word as holding a pointer instead of data. The other two raise a trap, one when the word is read and one when it is written. Requesters send one request per cycle with an opcode, a word address, write data and a tag of their own. Every request gets exactly one response two cycles later. The response carries a data word, one of four status codes and the same tag.

The block supports ordinary reads and writes, which do not look at the occupancy bit. It also supports two synchronizing accesses. A consuming read waits for the word to be full, then takes its data and leaves it empty. A producing write waits for the word to be empty, then fills it. The block never waits on its own: a synchronizing access that cannot go ahead returns a retry status, and the requester decides what to do next. The trap bits and the pointer bit are checked before the occupancy bit, so a requester learns of a trap or a pointer before anything is changed. A privileged opcode writes the four state bits directly, so that software can set up the locks, pointers and traps.

Top module: `tmw_ctrl`

## Requirements
- R1: After reset, every word holds data 0 with all four state bits clear (empty, no pointer, no traps), and `rsp_valid` is low.
- R2: A request accepted on a clock edge (`req_valid` high) gets exactly one response: `rsp_valid` is high in the second cycle after the cycle that carried the request, and `rsp_tag` equals the request's tag. `rsp_valid` is never high at any other time.
- R3: A plain read (opcode 0) returns the word's data with status DONE (code 0) whether the word is full or empty, and it changes no state.
- R4: A plain write (opcode 1) stores `req_data`, sets the word full, returns DONE with data 0, and leaves the pointer and trap bits unchanged.
- R5: A consuming read (opcode 2) of a full word returns its data with DONE and leaves the word empty. On an empty word it returns RETRY (code 1) with data 0 and changes nothing.
- R6: A producing write (opcode 3) to an empty word stores `req_data`, sets the word full and returns DONE. On a full word it returns RETRY with data 0 and changes nothing.
- R7: If the word's pointer bit is set, any read or write that is not trapped returns status FORWARDED (code 2) with the stored pointer as data, and changes nothing.
- R8: The read-trap bit traps opcodes 0 and 2. The write-trap bit traps opcodes 1 and 3. A trapped access returns TRAP (code 3) with data 0 and changes nothing. Trap takes priority over the pointer bit and over the occupancy bit. Each trap bit has no effect on the other kind of access.
- R9: The set-state opcode (4) copies `req_data[3:0]` into the state bits in the order bit 3 write-trap, bit 2 read-trap, bit 1 pointer, bit 0 full. It leaves the data untouched, ignores any trap or pointer bits already set, and returns DONE with data 0.
- R10: Opcodes 5 to 7 are reserved. They return TRAP with data 0 and change nothing.
- R11: Requests on consecutive cycles to the same word each see the state left by the request before them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Opcode (0 read, 1 write, 2 consuming read, 3 producing write, 4 set state, 5-7 reserved) |
| req_addr | input | ADDR_W | Word address |
| req_data | input | 64 | Write data, or new state bits for opcode 4 |
| req_tag | input | TAG_W | Requester tag, returned unchanged |
| rsp_valid | output | 1 | Response present this cycle |
| rsp_data | output | 64 | Read data or forwarded pointer |
| rsp_status | output | 2 | 0 DONE, 1 RETRY, 2 FORWARDED, 3 TRAP |
| rsp_tag | output | TAG_W | Tag of the request answered |

## Verification
The hardest situation to reach is a word with several state bits set at once. Such a word is the only place where the order of the trap, pointer and occupancy checks can be observed. The stimulus builds these words explicitly with the set-state opcode: read-trap together with pointer and full, then write-trap with full. It then issues both kinds of access against them. After each trapped or forwarded access it reads the word back through the normal path, to show that the data and the lock were left alone. A randomized phase follows that mixes all eight opcodes on a few words in back-to-back cycles, so that lock handoffs between adjacent requests are exercised as well.

// File: rtl/tmw_pkg.sv
package tmw_pkg;
  localparam int WORD_W   = 64;
  localparam int STATE_W  = 4;

  localparam logic [2:0] OP_RD       = 3'd0;
  localparam logic [2:0] OP_WR       = 3'd1;
  localparam logic [2:0] OP_RD_TAKE  = 3'd2;
  localparam logic [2:0] OP_WR_GIVE  = 3'd3;
  localparam logic [2:0] OP_SET_ST   = 3'd4;

  typedef enum logic [1:0] {
    RS_DONE  = 2'd0,
    RS_RETRY = 2'd1,
    RS_FWD   = 2'd2,
    RS_TRAP  = 2'd3
  } rsp_status_e;

  typedef struct packed {
    logic trap_wr;
    logic trap_rd;
    logic is_ptr;
    logic full;
  } word_state_t;
endpackage

// File: rtl/tmw_word_store.sv
module tmw_word_store
  import tmw_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [WORD_W-1:0] rd_data,
  output word_state_t       rd_state,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [WORD_W-1:0] wr_data,
  input  word_state_t       wr_state
);
  logic [WORD_W-1:0] data_q  [DEPTH];
  word_state_t       state_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic sel;
    assign sel = wr_en && (wr_addr == ADDR_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_q[i]  <= '0;
        state_q[i] <= '0;
      end else if (sel) begin
        data_q[i]  <= wr_data;
        state_q[i] <= wr_state;
      end
    end
  end

  assign rd_data  = data_q[rd_addr];
  assign rd_state = state_q[rd_addr];
endmodule

// File: rtl/tmw_access_rules.sv
module tmw_access_rules
  import tmw_pkg::*;
(
  input  logic [2:0]        op,
  input  logic [WORD_W-1:0] op_data,
  input  logic [WORD_W-1:0] cur_data,
  input  word_state_t       cur_state,
  output rsp_status_e       status,
  output logic [WORD_W-1:0] out_data,
  output logic              upd,
  output logic [WORD_W-1:0] new_data,
  output word_state_t       new_state
);
  logic is_rd, is_wr, trapped;

  assign is_rd   = (op == OP_RD) || (op == OP_RD_TAKE);
  assign is_wr   = (op == OP_WR) || (op == OP_WR_GIVE);
  assign trapped = (is_rd && cur_state.trap_rd) || (is_wr && cur_state.trap_wr);

  always_comb begin
    status    = RS_DONE;
    out_data  = '0;
    upd       = 1'b0;
    new_data  = cur_data;
    new_state = cur_state;
    if (op == OP_SET_ST) begin
      upd       = 1'b1;
      new_state = word_state_t'(op_data[STATE_W-1:0]);
    end else if (!(is_rd || is_wr) || trapped) begin
      status = RS_TRAP;
    end else if (cur_state.is_ptr) begin
      status   = RS_FWD;
      out_data = cur_data;
    end else begin
      unique case (op)
        OP_RD: out_data = cur_data;
        OP_WR: begin
          upd            = 1'b1;
          new_data       = op_data;
          new_state.full = 1'b1;
        end
        OP_RD_TAKE: begin
          if (cur_state.full) begin
            out_data       = cur_data;
            upd            = 1'b1;
            new_state.full = 1'b0;
          end else begin
            status = RS_RETRY;
          end
        end
        default: begin
          if (!cur_state.full) begin
            upd            = 1'b1;
            new_data       = op_data;
            new_state.full = 1'b1;
          end else begin
            status = RS_RETRY;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/tmw_resp_pipe.sv
module tmw_resp_pipe #(
  parameter int PAY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [PAY_W-1:0] in_pay,
  output logic             out_valid,
  output logic [PAY_W-1:0] out_pay
);
  logic             v1_q, v2_q;
  logic [PAY_W-1:0] p1_q, p2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= in_valid;
      v2_q <= v1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      p1_q <= '0;
      p2_q <= '0;
    end else begin
      if (in_valid) p1_q <= in_pay;
      if (v1_q)     p2_q <= p1_q;
    end
  end

  assign out_valid = v2_q;
  assign out_pay   = p2_q;
endmodule

// File: rtl/tmw_ctrl.sv
module tmw_ctrl
  import tmw_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int TAG_W  = 8,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_data,
  input  logic [TAG_W-1:0]  req_tag,
  output logic              rsp_valid,
  output logic [63:0]       rsp_data,
  output logic [1:0]        rsp_status,
  output logic [TAG_W-1:0]  rsp_tag
);
  localparam int PAY_W = WORD_W + 2 + TAG_W;

  logic [WORD_W-1:0] cur_data, out_data, new_data;
  word_state_t       cur_state, new_state;
  rsp_status_e       status;
  logic              upd;
  logic [PAY_W-1:0]  pay_in, pay_out;

  tmw_word_store #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_addr  (req_addr),
    .rd_data  (cur_data),
    .rd_state (cur_state),
    .wr_en    (req_valid && upd),
    .wr_addr  (req_addr),
    .wr_data  (new_data),
    .wr_state (new_state)
  );

  tmw_access_rules u_rules (
    .op        (req_op),
    .op_data   (req_data),
    .cur_data  (cur_data),
    .cur_state (cur_state),
    .status    (status),
    .out_data  (out_data),
    .upd       (upd),
    .new_data  (new_data),
    .new_state (new_state)
  );

  assign pay_in = {out_data, status, req_tag};

  tmw_resp_pipe #(.PAY_W(PAY_W)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (req_valid),
    .in_pay    (pay_in),
    .out_valid (rsp_valid),
    .out_pay   (pay_out)
  );

  assign rsp_data   = pay_out[PAY_W-1 -: WORD_W];
  assign rsp_status = pay_out[TAG_W +: 2];
  assign rsp_tag    = pay_out[TAG_W-1:0];
endmodule

// File: rtl/tmw_ctrl_chk.sv
module tmw_ctrl_chk
  import tmw_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [2:0]       req_op,
  input logic [TAG_W-1:0] req_tag,
  input logic             rsp_valid,
  input logic [63:0]      rsp_data,
  input logic [1:0]       rsp_status,
  input logic [TAG_W-1:0] rsp_tag
);
  logic [1:0] age_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          age_q <= 2'd0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R2: response two cycles after each request
  a_r2_resp_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> ##1 rsp_valid);

  // R2: no response without a request two cycles earlier
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && rsp_valid) |-> $past(req_valid, 2));

  // R2: tag carried through
  a_r2_tag_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && rsp_valid) |-> rsp_tag == $past(req_tag, 2));

  // R5, R6: retry responses carry no data
  a_r5_retry_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd1) |-> rsp_data == '0);

  // R8: trap responses carry no data
  a_r8_trap_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_status == 2'd3) |-> rsp_data == '0);

  // R9: set-state always completes with data 0
  a_r9_set_done: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && rsp_valid && $past(req_op, 2) == OP_SET_ST)
      |-> (rsp_status == 2'd0 && rsp_data == '0));

  // R10: reserved opcodes trap
  a_r10_reserved_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q >= 2'd2 && rsp_valid && $past(req_op, 2) > 3'd4) |-> rsp_status == 2'd3);

  // R1: quiet output right after reset
  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (age_q < 2'd2) |-> !rsp_valid);
endmodule

bind tmw_ctrl tmw_ctrl_chk #(.TAG_W(TAG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_op     (req_op),
  .req_tag    (req_tag),
  .rsp_valid  (rsp_valid),
  .rsp_data   (rsp_data),
  .rsp_status (rsp_status),
  .rsp_tag    (rsp_tag)
);

// File: tb/tb_tmw_ctrl.sv
`timescale 1ns/1ps
module tb_tmw_ctrl;
  localparam int DEPTH = 16;
  localparam int AW    = 4;
  localparam int TW    = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic [2:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [63:0]   req_data;
  logic [TW-1:0] req_tag;
  logic          rsp_valid;
  logic [63:0]   rsp_data;
  logic [1:0]    rsp_status;
  logic [TW-1:0] rsp_tag;

  always #4 clk = ~clk;

  tmw_ctrl #(.DEPTH(DEPTH), .TAG_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_data(req_data), .req_tag(req_tag),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_status(rsp_status),
    .rsp_tag(rsp_tag)
  );

  typedef struct {
    int          due;
    logic [1:0]  st;
    logic [63:0] d;
    logic [TW-1:0] tag;
    string       req;
  } exp_t;

  exp_t        expq[$];
  logic [63:0] m_data [DEPTH];
  logic [3:0]  m_st   [DEPTH];  // {trap_wr, trap_rd, ptr, full}
  int          n_tests = 0, n_fail = 0, step_no = 0;
  logic [TW-1:0] tag_ctr = '0;
  bit          finished = 0;

  // behavioural reference of one access; updates model state
  task automatic model(input logic [2:0] op, input int a, input logic [63:0] wd,
                       output logic [1:0] st, output logic [63:0] d);
    bit rd = (op == 0 || op == 2);
    bit wr = (op == 1 || op == 3);
    st = 0; d = 0;
    if (op == 4)                                    m_st[a] = wd[3:0];
    else if (!(rd || wr))                           st = 3;
    else if ((rd && m_st[a][2]) || (wr && m_st[a][3])) st = 3;
    else if (m_st[a][1]) begin st = 2; d = m_data[a]; end
    else if (op == 0) d = m_data[a];
    else if (op == 1) begin m_data[a] = wd; m_st[a][0] = 1; end
    else if (op == 2) begin
      if (m_st[a][0]) begin d = m_data[a]; m_st[a][0] = 0; end else st = 1;
    end else begin
      if (!m_st[a][0]) begin m_data[a] = wd; m_st[a][0] = 1; end else st = 1;
    end
  endtask

  task automatic check_out();
    n_tests++;
    if (expq.size() > 0 && expq[0].due == step_no) begin
      exp_t e = expq.pop_front();
      if (!rsp_valid || rsp_status !== e.st || rsp_data !== e.d || rsp_tag !== e.tag) begin
        n_fail++;
        $display("FAIL %s step %0d: got v=%b st=%0d d=%h tag=%0d exp v=1 st=%0d d=%h tag=%0d",
                 e.req, step_no, rsp_valid, rsp_status, rsp_data, rsp_tag, e.st, e.d, e.tag);
      end
    end else if (rsp_valid !== 1'b0) begin
      n_fail++;
      $display("FAIL R2 step %0d: got rsp_valid=%b exp 0", step_no, rsp_valid);
    end
  endtask

  task automatic step(input bit v, input logic [2:0] op, input int a,
                      input logic [63:0] wd, input string rq);
    @(negedge clk);
    step_no++;
    check_out();
    req_valid = v; req_op = op; req_addr = AW'(a); req_data = wd; req_tag = tag_ctr;
    if (v) begin
      exp_t e;
      model(op, a, wd, e.st, e.d);
      e.due = step_no + 2; e.tag = tag_ctr; e.req = rq;
      expq.push_back(e);
      tag_ctr = tag_ctr + 1'b1;
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, "R2");
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) begin m_data[i] = 0; m_st[i] = 0; end
    rst_n = 0; req_valid = 0; req_op = 0; req_addr = 0; req_data = 0; req_tag = 0;
    repeat (3) @(negedge clk);
    n_tests++;
    if (rsp_valid !== 1'b0) begin
      n_fail++; $display("FAIL R1: rsp_valid=%b in reset exp 0", rsp_valid);
    end
    rst_n = 1;
    idle(2);
    // R1: reset contents
    step(1, 0, 3, 0, "R1");
    step(1, 2, 3, 0, "R1");
    // R4, R5, R3
    step(1, 1, 1, 64'hA5A5_0000_1111_2222, "R4");
    step(1, 2, 1, 0, "R5");
    step(1, 2, 1, 0, "R5");
    step(1, 0, 1, 0, "R3");
    // R6
    step(1, 3, 2, 64'hBEEF, "R6");
    step(1, 3, 2, 64'hCAFE, "R6");
    step(1, 0, 2, 0, "R6");
    // R11: back to back on one word
    step(1, 3, 4, 64'h44, "R11");
    step(1, 2, 4, 0, "R11");
    step(1, 2, 4, 0, "R11");
    step(1, 3, 4, 64'h55, "R11");
    // R9, R7: pointer word
    step(1, 1, 5, 64'h0000_0000_0000_0ABC, "R4");
    step(1, 4, 5, 64'hFFFF_FFFF_FFFF_FFF3, "R9");
    step(1, 0, 5, 0, "R7");
    step(1, 3, 5, 64'h999, "R7");
    step(1, 2, 5, 0, "R7");
    step(1, 4, 5, 64'h1, "R9");
    step(1, 0, 5, 0, "R7");
    // R8: trap priority
    step(1, 1, 6, 64'hD00D, "R4");
    step(1, 4, 6, 64'h7, "R9");
    step(1, 0, 6, 0, "R8");
    step(1, 2, 6, 0, "R8");
    step(1, 1, 6, 64'hE, "R8");
    step(1, 4, 6, 64'h9, "R9");
    step(1, 3, 6, 64'hF, "R8");
    step(1, 1, 6, 64'hF, "R8");
    step(1, 0, 6, 0, "R8");
    step(1, 2, 6, 0, "R8");
    // R10: reserved opcodes
    step(1, 5, 1, 64'h1, "R10");
    step(1, 6, 1, 64'h2, "R10");
    step(1, 7, 1, 64'h3, "R10");
    step(1, 0, 1, 0, "R10");
    idle(3);
    // randomized mix on a few words
    for (int i = 0; i < 400; i++) begin
      logic [2:0]  op = 3'($urandom_range(0, 7));
      logic [63:0] wd = {$urandom, $urandom};
      if (op == 4)
        wd = ($urandom_range(0, 5) == 0) ? 64'($urandom_range(0, 15)) : 64'($urandom_range(0, 3));
      if ($urandom_range(0, 4) == 0) step(0, 0, 0, 0, "R2");
      else step(1, op, $urandom_range(8, 11), wd, "R11");
    end
    idle(4);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule